// File: doc/BRIEF.md
# Delayed-Branch Microsequencer with Opcode Dispatch

This block produces the micro-program counter for a microcoded floating-point unit whose 512-word control store is read every cycle. The microword at the current micro-PC is returned on `uword_i`. It supplies a default successor address, a two-bit sequencing operation, three branch-enable bits and three condition selectors. A word's branch enables are captured together with the condition values they select. They reach the address one cycle late: they are ORed into the low three bits of the successor of the word that follows. There is no stall input, so microcode waits by branching on conditions.

Several sources can override the default successor:
- a flush, which returns to idle,
- a parity-error entry point,
- an external trap vector,
- a diagnostic entry point,
- opcode dispatch when an instruction starts,
- a single-level call/return.

The dispatched start address goes unchanged to every sequencer lane, and the lanes then run independently. The format bits that go with a dispatched opcode are held on `fmt_o` until the next dispatch or flush.

Top module: `useq_core`

## Requirements
- R1: While reset is applied and after it is released, every lane's micro-PC is 0, `fmt_o` is 0 and every `perr_o` bit is 0.
- R2: A flush has the highest priority. The next micro-PC of every lane is 0, the return register becomes 0, the pending branch bits are cleared and `fmt_o` becomes 0.
- R3: A microword whose 48 bits have odd parity (bit 47 is the even-parity bit) forces that lane's next micro-PC to `PERR_ADDR` unless a flush is present. It also clears that lane's pending bits and sets that lane's `perr_o` bit. The `perr_o` bit then stays set until reset.
- R4: A trap request, when there is no flush and no parity error, loads `trap_vec_i` into the micro-PC.
- R5: A diagnostic request, when there is no flush, parity error or trap, loads `DIAG_ADDR`.
- R6: A start strobe, when there is no flush, trap or diagnostic request, loads `DISP_BASE + 4*opcode` (mod 512) into every lane that has no parity error. In the same case `fmt_o` takes the top `FMT_W` bits of the opcode and holds them until the next dispatch or flush.
- R7: The operation field is bits 10:9. With no higher source, operation 3 (return) loads the lane's return register.
- R8: With no higher source, operation 2 (call) loads the next-address field (bits 8:0) and sets the return register to micro-PC+1 (mod 512). Operation 1 (jump) loads bits 8:0 exactly, and any pending branch bits are ignored.
- R9: With no higher source, operation 0 loads the next-address field ORed with the pending bits. Pending bit i equals enable bit 11+i ANDed with the condition input picked by the selector in bits 14+3i..16+3i, sampled in the cycle before.
- R10: A word's branch enables never change the micro-PC that immediately follows it. Only bits 2:0 of the successor after that one can change.
- R11: After a common dispatch, each lane follows only its own microword and conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_i | input | 1 | Instruction-stream change: return to idle |
| start_i | input | 1 | New instruction strobe |
| opcode_i | input | OP_W | Opcode used for dispatch |
| trap_i | input | 1 | External trap request |
| trap_vec_i | input | 9 | Trap target address |
| diag_i | input | 1 | Diagnostic entry request |
| cond_i | input | NSEQ*8 | Branch condition inputs, 8 per lane |
| uword_i | input | NSEQ*48 | Current microword of each lane |
| upc_o | output | NSEQ*9 | Micro-PC of each lane |
| fmt_o | output | FMT_W | Format bits of the last dispatched opcode |
| perr_o | output | NSEQ | Sticky parity-error flag per lane |

## Verification
The bench sweeps the delayed branch over every enable pattern against every condition pattern. A design that applied the enables one cycle early would show a change in the immediate successor. One that dropped the delay stage would never OR the bits in. A sweep over all 32 combinations of flush, bad parity, trap, diagnostic and start exposes any swapped priority, because each source lands on a distinct address. Other directed cases cover a jump after a pending branch, a return that wraps at address 511, a sweep over every opcode and lanes that diverge after a dispatch. A long mixed stream then catches errors in the return register or in the sticky parity flag.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int UPC_W  = 9;
    localparam int UW_W   = 48;
    localparam int NCOND  = 8;
    localparam int CSEL_W = $clog2(NCOND);
    localparam int NSLOT  = 3;

    localparam int F_NEXT = 0;
    localparam int F_OP   = F_NEXT + UPC_W;
    localparam int F_BEN  = F_OP + 2;
    localparam int F_CSEL = F_BEN + NSLOT;
    localparam int F_PAR  = UW_W - 1;

    typedef enum logic [1:0] {
        OP_SEQ  = 2'd0,
        OP_JUMP = 2'd1,
        OP_CALL = 2'd2,
        OP_RET  = 2'd3
    } uop_e;

    typedef struct packed {
        logic [UPC_W-1:0] upc;
        logic [UPC_W-1:0] ret;
        logic [NSLOT-1:0] pend;
        logic             perr;
    } lane_st_t;
endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int               OP_W      = 6,
    parameter int               FMT_W     = 2,
    parameter logic [UPC_W-1:0] DISP_BASE = 9'h100
) (
    input  logic [OP_W-1:0]  opcode_i,
    output logic [UPC_W-1:0] addr_o,
    output logic [FMT_W-1:0] fmt_o
);
    localparam int OFF_W = OP_W + 2;

    logic [OFF_W-1:0] off;

    always_comb begin
        off    = {opcode_i, 2'b00};
        addr_o = DISP_BASE + UPC_W'(off);
        fmt_o  = opcode_i[OP_W-1 -: FMT_W];
    end
endmodule

// File: rtl/useq_lane.sv
module useq_lane
    import useq_pkg::*;
#(
    parameter logic [UPC_W-1:0] PERR_ADDR = 9'h0F8,
    parameter logic [UPC_W-1:0] DIAG_ADDR = 9'h0E0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             trap_i,
    input  logic [UPC_W-1:0] trap_vec_i,
    input  logic             diag_i,
    input  logic             start_i,
    input  logic [UPC_W-1:0] disp_addr_i,
    input  logic [NCOND-1:0] cond_i,
    input  logic [UW_W-1:0]  uword_i,
    output logic [UPC_W-1:0] upc_o,
    output logic             perr_o
);
    lane_st_t         st_d, st_q;
    logic             par_bad;
    uop_e             op;
    logic [UPC_W-1:0] nxt;
    logic [NSLOT-1:0] hit;
    logic [UPC_W-1:0] link;

    always_comb begin
        par_bad = ^uword_i;
        op      = uop_e'(uword_i[F_OP +: 2]);
        nxt     = uword_i[F_NEXT +: UPC_W];
        link    = st_q.upc + UPC_W'(1);
        for (int i = 0; i < NSLOT; i++) begin
            hit[i] = uword_i[F_BEN + i] & cond_i[uword_i[F_CSEL + CSEL_W*i +: CSEL_W]];
        end

        st_d = st_q;
        if (flush_i) begin
            st_d.upc  = '0;
            st_d.ret  = '0;
            st_d.pend = '0;
        end else if (par_bad) begin
            st_d.upc  = PERR_ADDR;
            st_d.perr = 1'b1;
            st_d.pend = '0;
        end else begin
            st_d.pend = hit;
            if (trap_i) begin
                st_d.upc = trap_vec_i;
            end else if (diag_i) begin
                st_d.upc = DIAG_ADDR;
            end else if (start_i) begin
                st_d.upc = disp_addr_i;
            end else begin
                unique case (op)
                    OP_RET:  st_d.upc = st_q.ret;
                    OP_CALL: begin
                        st_d.upc = nxt;
                        st_d.ret = link;
                    end
                    OP_JUMP: st_d.upc = nxt;
                    default: st_d.upc = nxt | UPC_W'(st_q.pend);
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upc_o  = st_q.upc;
    assign perr_o = st_q.perr;

    logic quiet;
    assign quiet = !flush_i && !par_bad && !trap_i && !diag_i && !start_i;

    a_r2_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.upc == '0) && (st_q.pend == '0));
    a_r3_perr_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && par_bad) |=> (st_q.upc == PERR_ADDR) && st_q.perr);
    a_r3_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.perr |=> st_q.perr);
    a_r4_trap_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !par_bad && trap_i) |=> st_q.upc == $past(trap_vec_i));
    a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && op == OP_RET) |=> st_q.upc == $past(st_q.ret));
    a_r8_call_link: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && op == OP_CALL) |=> st_q.ret == $past(st_q.upc) + UPC_W'(1));
    a_r10_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && op == OP_SEQ) |=> st_q.upc[UPC_W-1:NSLOT] == $past(nxt[UPC_W-1:NSLOT]));
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int               NSEQ      = 2,
    parameter int               OP_W      = 6,
    parameter int               FMT_W     = 2,
    parameter logic [UPC_W-1:0] DISP_BASE = 9'h100,
    parameter logic [UPC_W-1:0] PERR_ADDR = 9'h0F8,
    parameter logic [UPC_W-1:0] DIAG_ADDR = 9'h0E0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    input  logic                  start_i,
    input  logic [OP_W-1:0]       opcode_i,
    input  logic                  trap_i,
    input  logic [UPC_W-1:0]      trap_vec_i,
    input  logic                  diag_i,
    input  logic [NSEQ*NCOND-1:0] cond_i,
    input  logic [NSEQ*UW_W-1:0]  uword_i,
    output logic [NSEQ*UPC_W-1:0] upc_o,
    output logic [FMT_W-1:0]      fmt_o,
    output logic [NSEQ-1:0]       perr_o
);
    logic [UPC_W-1:0] disp_addr;
    logic [FMT_W-1:0] disp_fmt;
    logic [FMT_W-1:0] fmt_d, fmt_q;
    logic             disp_win;

    useq_dispatch #(
        .OP_W     (OP_W),
        .FMT_W    (FMT_W),
        .DISP_BASE(DISP_BASE)
    ) u_disp (
        .opcode_i(opcode_i),
        .addr_o  (disp_addr),
        .fmt_o   (disp_fmt)
    );

    always_comb begin
        disp_win = start_i && !flush_i && !trap_i && !diag_i;
        fmt_d    = fmt_q;
        if (flush_i)       fmt_d = '0;
        else if (disp_win) fmt_d = disp_fmt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fmt_q <= '0;
        else        fmt_q <= fmt_d;
    end

    assign fmt_o = fmt_q;

    for (genvar g = 0; g < NSEQ; g++) begin : g_lane
        useq_lane #(
            .PERR_ADDR(PERR_ADDR),
            .DIAG_ADDR(DIAG_ADDR)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush_i    (flush_i),
            .trap_i     (trap_i),
            .trap_vec_i (trap_vec_i),
            .diag_i     (diag_i),
            .start_i    (start_i),
            .disp_addr_i(disp_addr),
            .cond_i     (cond_i[g*NCOND +: NCOND]),
            .uword_i    (uword_i[g*UW_W +: UW_W]),
            .upc_o      (upc_o[g*UPC_W +: UPC_W]),
            .perr_o     (perr_o[g])
        );
    end

    a_r6_fmt_load: assert property (@(posedge clk) disable iff (!rst_n)
        disp_win |=> fmt_q == $past(opcode_i[OP_W-1 -: FMT_W]));
    a_r2_fmt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> fmt_q == '0);
endmodule

// File: tb/test_useq_core.sv
module test_useq_core;
    localparam int NSEQ = 2;
    localparam logic [8:0] PERR = 9'h0F8;
    localparam logic [8:0] DIAG = 9'h0E0;
    localparam logic [8:0] DBASE = 9'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0, start = 1'b0, trap = 1'b0, diag = 1'b0;
    logic [5:0]  opcode = '0;
    logic [8:0]  tvec = '0;
    logic [47:0] uw0 = '0, uw1 = '0;
    logic [7:0]  c0 = '0, c1 = '0;
    logic [17:0] upc;
    logic [1:0]  fmt;
    logic [1:0]  perr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [8:0] m_upc[2];
    logic [8:0] m_ret[2];
    logic [2:0] m_pend[2];
    logic       m_perr[2];
    logic [1:0] m_fmt;

    always #5 clk = ~clk;

    useq_core i_useq_core (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .start_i(start),
        .opcode_i(opcode), .trap_i(trap), .trap_vec_i(tvec), .diag_i(diag),
        .cond_i({c1, c0}), .uword_i({uw1, uw0}),
        .upc_o(upc), .fmt_o(fmt), .perr_o(perr)
    );

    function automatic logic [47:0] mkword(input logic [8:0] nxt, input logic [1:0] op,
                                           input logic [2:0] ben, input logic [2:0] s0,
                                           input logic [2:0] s1, input logic [2:0] s2,
                                           input logic [23:0] spare);
        logic [47:0] w;
        w = '0;
        w[8:0] = nxt; w[10:9] = op; w[13:11] = ben;
        w[16:14] = s0; w[19:17] = s1; w[22:20] = s2;
        w[46:23] = spare;
        w[47] = ^w[46:0];
        return w;
    endfunction

    task automatic check(input string tag, input string what, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        flush = 0; start = 0; trap = 0; diag = 0;
        uw0 = mkword(9'h000, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0);
        uw1 = uw0; c0 = '0; c1 = '0;
    endtask

    task automatic step(input string ovr);
        string tag[2];
        for (int l = 0; l < 2; l++) begin
            logic [47:0] w;
            logic [7:0]  c;
            logic [2:0]  h;
            w = (l == 0) ? uw0 : uw1;
            c = (l == 0) ? c0 : c1;
            for (int i = 0; i < 3; i++) h[i] = w[11+i] & c[w[14+3*i +: 3]];
            if (flush) begin
                m_upc[l] = 0; m_ret[l] = 0; m_pend[l] = 0; tag[l] = "R2";
            end else if (^w) begin
                m_upc[l] = PERR; m_perr[l] = 1; m_pend[l] = 0; tag[l] = "R3";
            end else begin
                if (trap) begin m_upc[l] = tvec; tag[l] = "R4"; end
                else if (diag) begin m_upc[l] = DIAG; tag[l] = "R5"; end
                else if (start) begin m_upc[l] = DBASE + {1'b0, opcode, 2'b00}; tag[l] = "R6"; end
                else begin
                    case (w[10:9])
                        2'd3: begin m_upc[l] = m_ret[l]; tag[l] = "R7"; end
                        2'd2: begin m_ret[l] = m_upc[l] + 9'd1; m_upc[l] = w[8:0]; tag[l] = "R8"; end
                        2'd1: begin m_upc[l] = w[8:0]; tag[l] = "R8"; end
                        default: begin m_upc[l] = w[8:0] | {6'd0, m_pend[l]}; tag[l] = "R9"; end
                    endcase
                end
                m_pend[l] = h;
            end
            if (ovr != "") tag[l] = ovr;
        end
        if (flush) m_fmt = 0;
        else if (start && !trap && !diag) m_fmt = opcode[5:4];
        @(posedge clk); #2;
        for (int l = 0; l < 2; l++) begin
            check(tag[l], $sformatf("lane%0d upc", l), upc[l*9 +: 9], m_upc[l]);
            check("R3", $sformatf("lane%0d perr", l), {8'd0, perr[l]}, {8'd0, m_perr[l]});
        end
        check(flush ? "R2" : "R6", "fmt", {7'd0, fmt}, {7'd0, m_fmt});
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 2; l++) begin
            m_upc[l] = 0; m_ret[l] = 0; m_pend[l] = 0; m_perr[l] = 0;
        end
        m_fmt = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "lane0 upc", upc[8:0], 9'h0);
        check("R1", "lane1 upc", upc[17:9], 9'h0);
        check("R1", "fmt", {7'd0, fmt}, 9'h0);
        check("R1", "perr", {7'd0, perr}, 9'h0);

        // R6 dispatch sweep over every opcode
        for (int op = 0; op < 64; op++) begin
            idle(); start = 1; opcode = 6'(op);
            step("R6");
            idle(); step("");
        end

        // R9 / R10 delayed branch: every enable pattern vs every condition pattern
        for (int b = 0; b < 8; b++) begin
            for (int cv = 0; cv < 8; cv++) begin
                idle(); step("");
                uw0 = mkword(9'h040, 2'd0, 3'(b), 3'd2, 3'd5, 3'd7, 24'h5A5A5A);
                uw1 = mkword(9'h040, 2'd0, ~3'(b), 3'd7, 3'd0, 3'd3, 24'h0);
                c0 = 8'((cv & 1) << 2 | ((cv >> 1) & 1) << 5 | ((cv >> 2) & 1) << 7);
                c1 = 8'((cv & 1) << 7 | ((cv >> 1) & 1) << 0 | ((cv >> 2) & 1) << 3);
                step("R10");
                uw0 = mkword(9'h088, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0);
                uw1 = uw0; c0 = '0; c1 = '0;
                step("R9");
            end
        end

        // R8 jump ignores pending bits
        idle(); step("");
        uw0 = mkword(9'h030, 2'd0, 3'b111, 3'd0, 3'd1, 3'd2, 24'h0); uw1 = uw0;
        c0 = 8'hFF; c1 = 8'hFF; step("R10");
        uw0 = mkword(9'h0A0, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0); uw1 = uw0;
        c0 = '0; c1 = '0; step("R8");

        // R7 / R8 call and return, including wrap at 511
        idle(); uw0 = mkword(9'h1FF, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0); uw1 = uw0; step("R8");
        uw0 = mkword(9'h070, 2'd2, 3'd0, 3'd0, 3'd0, 3'd0, 24'h1); uw1 = uw0; step("R8");
        uw0 = mkword(9'h071, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0); uw1 = uw0; step("R9");
        uw0 = mkword(9'h000, 2'd3, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0); uw1 = uw0; step("R7");

        // R11 lanes diverge after a common dispatch
        idle(); start = 1; opcode = 6'd5; step("R11");
        idle();
        uw0 = mkword(9'h011, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0);
        uw1 = mkword(9'h022, 2'd2, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0);
        step("R11");
        uw0 = mkword(9'h000, 2'd3, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0);
        uw1 = uw0; step("R11");

        // priority sweep over flush, bad parity, trap, diag, start
        for (int k = 0; k < 32; k++) begin
            idle(); step("");
            flush = k[0]; trap = k[2]; diag = k[3]; start = k[4];
            opcode = 6'(k + 3); tvec = 9'h0AB;
            uw0 = mkword(9'h055, 2'd2, 3'd0, 3'd0, 3'd0, 3'd0, 24'h0);
            uw1 = uw0;
            uw0[47] = uw0[47] ^ k[1];
            uw1[47] = uw1[47] ^ (k[1] & k[4]);
            step("");
        end

        // mixed stream
        for (int n = 0; n < 3000; n++) begin
            flush  = ($urandom_range(0, 31) == 0);
            trap   = ($urandom_range(0, 15) == 0);
            diag   = ($urandom_range(0, 31) == 0);
            start  = ($urandom_range(0, 7) == 0);
            opcode = 6'($urandom);
            tvec   = 9'($urandom);
            uw0 = mkword(9'($urandom), 2'($urandom), 3'($urandom), 3'($urandom),
                         3'($urandom), 3'($urandom), 24'($urandom));
            uw1 = mkword(9'($urandom), 2'($urandom), 3'($urandom), 3'($urandom),
                         3'($urandom), 3'($urandom), 24'($urandom));
            if ($urandom_range(0, 63) == 0) uw0[47] = ~uw0[47];
            if ($urandom_range(0, 63) == 0) uw1[47] = ~uw1[47];
            c0 = 8'($urandom); c1 = 8'($urandom);
            step("");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule